// File: doc/BRIEF.md
# Dual-Channel Counted-Window PLL Lock Detector

This block judges, for each of two synthesizer channels, whether the loop has settled. Everything runs on the oscillator clock. The block takes three single-cycle strobes: one from the shared reference divider and one from each channel's divider. It compares when the reference edge and the divider edge arrive. An edge pair counts as aligned when the two edges land less than two oscillator periods apart. A channel's lock flag rises only after a run of aligned reference cycles. Any misaligned, missing or stray edge clears the run at once.

One selector drives a single shared lock pin. In normal operation it shows one of these: constant low, channel 1, channel 2, or the AND of both. A channel held in standby always reports lock high. In test operation the same pin shows internal signals instead: the prescaler monitors, the divider strobes, the reference strobe, or the oscillator divided by two. The open-drain pad and the analog phase detector lie outside the block.

Top module: `lkd_dual`

## Requirements
- R1: After reset, `lock1` and `lock2` are low, and `ld_pin` is low when `ld_sel` = 2'b11 and `test_en` = 0.
- R2: A reference strobe with the channel strobe in the same cycle, one cycle earlier or one cycle later scores as aligned.
- R3: A channel strobe two or more cycles away from the reference strobe, before or after, scores as misaligned. A gap of exactly two cycles is misaligned.
- R4: A channel's lock rises only on the fourth consecutive aligned reference cycle. After three aligned cycles it is still low.
- R5: A single misaligned score drops a held lock within two cycles of the later edge. The run then restarts, so four more aligned cycles are needed.
- R6: A reference strobe with no channel strobe within one cycle scores as misaligned. So does a channel strobe with no reference strobe within one cycle.
- R7: While `stby1`/`stby2` is high, that channel's lock reads high and its run is cleared. After standby is released, the lock is low until four new aligned cycles.
- R8: With `test_en` = 0, `ld_sel` selects the pin: 2'b00 gives constant low, 2'b01 gives `lock2`, 2'b10 gives `lock1`, and 2'b11 gives `lock1` AND `lock2`.
- R9: With `test_en` = 1, the code {`stby2`,`ld_sel`} selects the pin: 000 `pres1_mon`, 001 `div1_edge`, 010 `ref_edge`, 011 the oscillator divided by two (toggles every cycle), 100 `pres2_mon`, 101 `div2_edge`, 110 `ref_edge`, 111 constant low.
- R10: The two channels score and lock independently on the same reference strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; time base for edge comparison |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_edge | input | 1 | Reference-divider output strobe |
| div1_edge | input | 1 | Channel 1 divider output strobe |
| div2_edge | input | 1 | Channel 2 divider output strobe |
| pres1_mon | input | 1 | Channel 1 prescaler monitor (test tap) |
| pres2_mon | input | 1 | Channel 2 prescaler monitor (test tap) |
| test_en | input | 1 | Selects test taps on the lock pin |
| stby1 | input | 1 | Channel 1 standby |
| stby2 | input | 1 | Channel 2 standby; also the top bit of the test tap code |
| ld_sel | input | 2 | Lock-pin selection code |
| lock1 | output | 1 | Channel 1 lock flag |
| lock2 | output | 1 | Channel 2 lock flag |
| ld_pin | output | 1 | Shared lock pin level |

## Verification
Two kinds of internal fault show up quickly at the ports. A corrupt edge history makes a misaligned pair leave the lock high, which is visible two cycles after the later edge. It can also make an aligned pair drop the lock. A run counter that is off by one moves the rising edge of `lock1`/`lock2` by one reference cycle, so the bench checks lock after each pair: low after the third aligned pair, high after the fourth. Selector faults show on `ld_pin` in the same cycle the select code changes. The oscillator-half tap must differ on consecutive cycles.

// File: rtl/lkd_pkg.sv
package lkd_pkg;

  // Test tap codes, formed as {stby2, ld_sel}
  typedef enum logic [2:0] {
    TAP_PRES1 = 3'b000,
    TAP_DIV1  = 3'b001,
    TAP_REF   = 3'b010,
    TAP_OSC2  = 3'b011,
    TAP_PRES2 = 3'b100,
    TAP_DIV2  = 3'b101,
    TAP_REF_B = 3'b110,
    TAP_LOW   = 3'b111
  } lkd_tap_e;

  // Normal-mode pin choice from the lock-control code
  function automatic logic pick_normal(input logic [1:0] sel,
                                       input logic l1, input logic l2);
    case (sel)
      2'b00:   pick_normal = 1'b0;
      2'b01:   pick_normal = l2;
      2'b10:   pick_normal = l1;
      default: pick_normal = l1 & l2;
    endcase
  endfunction

  // Next run count: saturating increment on an aligned score
  function automatic int unsigned run_next(input int unsigned cur,
                                           input int unsigned top);
    run_next = (cur >= top) ? top : cur + 1;
  endfunction

endpackage

// File: rtl/lkd_scorer.sv
// Scores each reference or divider edge once, DLY cycles after it,
// against a partner window spanning +/- DLY cycles.
module lkd_scorer #(
  parameter int WIN = 2            // alignment must be strictly below WIN cycles (WIN >= 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  input  logic div_i,
  output logic good_o,
  output logic bad_o
);
  localparam int DLY  = WIN - 1;
  localparam int HLEN = 2 * DLY;

  logic [HLEN-1:0] ref_h, div_h;
  logic ref_due, div_due, ref_near, div_near;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_h <= '0;
      div_h <= '0;
    end else begin
      ref_h <= {ref_h[HLEN-2:0], ref_i};
      div_h <= {div_h[HLEN-2:0], div_i};
    end
  end

  // the edge being judged now happened DLY cycles ago
  assign ref_due  = ref_h[DLY-1];
  assign div_due  = div_h[DLY-1];
  assign ref_near = |{ref_h, ref_i};
  assign div_near = |{div_h, div_i};

  assign bad_o  = (ref_due & ~div_near) | (div_due & ~ref_near);
  assign good_o = ref_due & div_near & ~bad_o;

  // R2: a scored reference edge with a divider edge at the same time is aligned
  p_same_cycle_good_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_i && div_i) |-> ##DLY !bad_o);
endmodule

// File: rtl/lkd_qualifier.sv
module lkd_qualifier #(
  parameter int RUN = 4            // consecutive aligned cycles required
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stby_i,
  input  logic good_i,
  input  logic bad_i,
  output logic lock_o
);
  import lkd_pkg::*;
  localparam int CW = $clog2(RUN + 1);
  localparam logic [CW-1:0] TOP  = CW'(RUN);
  localparam logic [CW-1:0] LAST = CW'(RUN - 1);

  logic [CW-1:0] cnt;
  logic          lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n || stby_i || bad_i) begin
      cnt    <= '0;
      lock_q <= 1'b0;
    end else if (good_i) begin
      cnt <= CW'(run_next(int'(cnt), RUN));
      if (cnt >= LAST) lock_q <= 1'b1;
    end
  end

  assign lock_o = lock_q | stby_i;

  // R5: one misaligned score removes the lock on the next cycle
  p_bad_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bad_i |=> !lock_q);
  // R4: lock only rises on an aligned score that completes the run
  p_rise_needs_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> ($past(good_i) && $past(cnt) == LAST));
  p_cnt_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TOP);
  // R7: standby clears the run
  p_stby_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stby_i |=> (cnt == '0));
endmodule

// File: rtl/lkd_pinsel.sv
module lkd_pinsel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       test_en,
  input  logic       stby2,
  input  logic [1:0] ld_sel,
  input  logic       lock1,
  input  logic       lock2,
  input  logic       pres1,
  input  logic       pres2,
  input  logic       div1,
  input  logic       div2,
  input  logic       ref_s,
  output logic       pin_o
);
  import lkd_pkg::*;

  logic     osc_half;
  lkd_tap_e tap;

  always_ff @(posedge clk) begin
    if (!rst_n) osc_half <= 1'b0;
    else        osc_half <= ~osc_half;
  end

  assign tap = lkd_tap_e'({stby2, ld_sel});

  always_comb begin
    if (!test_en) pin_o = pick_normal(ld_sel, lock1, lock2);
    else begin
      case (tap)
        TAP_PRES1: pin_o = pres1;
        TAP_DIV1:  pin_o = div1;
        TAP_REF:   pin_o = ref_s;
        TAP_OSC2:  pin_o = osc_half;
        TAP_PRES2: pin_o = pres2;
        TAP_DIV2:  pin_o = div2;
        TAP_REF_B: pin_o = ref_s;
        default:   pin_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/lkd_dual.sv
module lkd_dual #(
  parameter int WIN = 2,
  parameter int RUN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_edge,
  input  logic       div1_edge,
  input  logic       div2_edge,
  input  logic       pres1_mon,
  input  logic       pres2_mon,
  input  logic       test_en,
  input  logic       stby1,
  input  logic       stby2,
  input  logic [1:0] ld_sel,
  output logic       lock1,
  output logic       lock2,
  output logic       ld_pin
);
  localparam int NCH = 2;

  logic [NCH-1:0] div_v, stby_v, good_v, bad_v, lock_v;

  assign div_v  = {div2_edge, div1_edge};
  assign stby_v = {stby2, stby1};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    lkd_scorer #(.WIN(WIN)) u_score (
      .clk(clk), .rst_n(rst_n), .ref_i(ref_edge), .div_i(div_v[c]),
      .good_o(good_v[c]), .bad_o(bad_v[c]));
    lkd_qualifier #(.RUN(RUN)) u_qual (
      .clk(clk), .rst_n(rst_n), .stby_i(stby_v[c]),
      .good_i(good_v[c]), .bad_i(bad_v[c]), .lock_o(lock_v[c]));
  end

  assign lock1 = lock_v[0];
  assign lock2 = lock_v[1];

  lkd_pinsel u_pin (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .stby2(stby2), .ld_sel(ld_sel),
    .lock1(lock1), .lock2(lock2), .pres1(pres1_mon), .pres2(pres2_mon),
    .div1(div1_edge), .div2(div2_edge), .ref_s(ref_edge), .pin_o(ld_pin));

  // R8: AND selection follows both channel flags
  p_and_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_en && ld_sel == 2'b11) |-> (ld_pin == (lock1 && lock2)));
  // R7: a channel in standby reads locked
  p_stby_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stby1 |-> lock1) and (stby2 |-> lock2));
  // R9: the divided-oscillator tap alternates while selected
  p_osc_tap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && test_en && $past(test_en) && {stby2, ld_sel} == 3'b011
     && $past({stby2, ld_sel}) == 3'b011) |-> (ld_pin != $past(ld_pin)));
endmodule

// File: tb/lkd_dual_bench.sv
`timescale 1ns/1ps
module lkd_dual_bench;
  localparam int NONE = 99;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_edge = 0, div1_edge = 0, div2_edge = 0, pres1_mon = 0, pres2_mon = 0;
  logic test_en = 0, stby1 = 0, stby2 = 0;
  logic [1:0] ld_sel = 2'b11;
  logic lock1, lock2, ld_pin;

  int checks = 0, errors = 0;
  int run1 = 0, run2 = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lkd_dual u_lkd_dual (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .div1_edge(div1_edge),
    .div2_edge(div2_edge), .pres1_mon(pres1_mon), .pres2_mon(pres2_mon),
    .test_en(test_en), .stby1(stby1), .stby2(stby2), .ld_sel(ld_sel),
    .lock1(lock1), .lock2(lock2), .ld_pin(ld_pin));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // score one edge situation in the bench's own terms
  function automatic int upd(input int run, input bit sb, input bit ref_on, input int off);
    bit has_div = (off != NONE);
    if (sb) return 0;
    if (ref_on) return (has_div && off >= -1 && off <= 1) ? run + 1 : 0;
    return has_div ? 0 : run;
  endfunction

  // one reference slot of 16 cycles; divider strobes at offset from cycle 4
  task automatic pair(input bit ref_on, input int o1, input int o2, input string req);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      ref_edge  = ref_on && (i == 4);
      div1_edge = (o1 != NONE) && (i == 4 + o1);
      div2_edge = (o2 != NONE) && (i == 4 + o2);
    end
    @(negedge clk);
    run1 = upd(run1, stby1, ref_on, o1);
    run2 = upd(run2, stby2, ref_on, o2);
    chk({req, " lock1"}, lock1, (run1 >= 4) || stby1);
    chk({req, " lock2"}, lock2, (run2 >= 4) || stby2);
  endtask

  task automatic lock_both();
    for (int k = 0; k < 4; k++) pair(1, 0, 0, "R4 build");
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 lock1", lock1, 1'b0);
    chk("R1 lock2", lock2, 1'b0);
    chk("R1 pin", ld_pin, 1'b0);
  endtask

  task automatic t_window();
    pair(1, -1, 1, "R2 offsets -1/+1");
    pair(1, 0, 0, "R2 offset 0");
    pair(1, 1, -1, "R2 offsets +1/-1");
    pair(1, 0, 0, "R2 fourth aligned");
    pair(1, 2, -2, "R3 offsets +2/-2");
    lock_both();
    pair(1, 3, -3, "R3 offsets +3/-3");
  endtask

  task automatic t_run();
    pair(1, NONE, NONE, "R6 missing divider");
    for (int k = 0; k < 3; k++) pair(1, 0, 1, "R4 below run");
    chk("R4 three aligned", lock1, 1'b0);
    pair(1, 0, 1, "R4 fourth aligned");
    chk("R4 locked", lock1, 1'b1);
  endtask

  task automatic t_drop();
    lock_both();
    pair(1, 2, 0, "R5 single miss");
    for (int k = 0; k < 3; k++) pair(1, 0, 0, "R5 restart");
    chk("R5 still low after three", lock1, 1'b0);
    pair(1, 0, 0, "R5 relock");
  endtask

  task automatic t_stray();
    lock_both();
    pair(0, 0, NONE, "R6 stray divider");
    chk("R6 stray drops ch1", lock1, 1'b0);
    chk("R10 ch2 untouched", lock2, 1'b1);
  endtask

  task automatic t_standby();
    @(negedge clk); stby1 = 1'b1;
    #1 chk("R7 standby high", lock1, 1'b1);
    pair(1, 3, 0, "R7 misaligned during standby");
    @(negedge clk); stby1 = 1'b0;
    #1 chk("R7 released low", lock1, 1'b0);
    for (int k = 0; k < 3; k++) pair(1, 0, 0, "R7 rebuild");
    pair(1, 0, 0, "R7 relocked");
  endtask

  task automatic t_independent();
    lock_both();
    pair(1, 0, 3, "R10 ch2 miss only");
    chk("R10 ch1 kept", lock1, 1'b1);
    chk("R10 ch2 dropped", lock2, 1'b0);
  endtask

  task automatic t_pin_normal();
    // lock1 = 1, lock2 = 0 on entry
    @(negedge clk); ld_sel = 2'b00; #1 chk("R8 sel 00", ld_pin, 1'b0);
    ld_sel = 2'b01; #1 chk("R8 sel 01", ld_pin, 1'b0);
    ld_sel = 2'b10; #1 chk("R8 sel 10", ld_pin, 1'b1);
    ld_sel = 2'b11; #1 chk("R8 sel 11", ld_pin, 1'b0);
    stby2 = 1'b1;   #1 chk("R8 and with standby ch2", ld_pin, 1'b1);
    ld_sel = 2'b00; #1 chk("R8 sel 00 forced low", ld_pin, 1'b0);
    stby2 = 1'b0; ld_sel = 2'b11; run2 = 0;
  endtask

  task automatic t_taps();
    logic first;
    @(negedge clk);
    test_en = 1'b1; stby2 = 1'b0; ld_sel = 2'b00;
    pres1_mon = 1'b1; #0.5 chk("R9 pres1 high", ld_pin, 1'b1);
    pres1_mon = 1'b0; #0.5 chk("R9 pres1 low", ld_pin, 1'b0);
    ld_sel = 2'b01; div1_edge = 1'b1; #0.5 chk("R9 div1", ld_pin, 1'b1);
    div1_edge = 1'b0;
    ld_sel = 2'b10; ref_edge = 1'b1; #0.5 chk("R9 ref", ld_pin, 1'b1);
    ref_edge = 1'b0;
    stby2 = 1'b1; ld_sel = 2'b00; pres2_mon = 1'b1; #0.5 chk("R9 pres2", ld_pin, 1'b1);
    pres2_mon = 1'b0;
    ld_sel = 2'b01; div2_edge = 1'b1; #0.5 chk("R9 div2", ld_pin, 1'b1);
    div2_edge = 1'b0;
    ld_sel = 2'b11; #0.5 chk("R9 code 111 low", ld_pin, 1'b0);
    stby2 = 1'b0; ld_sel = 2'b11;
    @(negedge clk); first = ld_pin;
    @(negedge clk); chk("R9 osc half toggles", ld_pin, ~first);
    @(negedge clk); chk("R9 osc half toggles again", ld_pin, first);
    test_en = 1'b0; run2 = 0;
  endtask

  initial begin
    t_reset();
    t_window();
    t_run();
    t_drop();
    t_stray();
    t_standby();
    t_independent();
    t_pin_normal();
    t_taps();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule